// File: doc/BRIEF.md
# Transactional Line Footprint Tracker

This block records which lines of a small data cache a running transaction has touched, and it defends that footprint against coherence invalidations from other agents. Every line carries two marks. A read mark is set when a transactional access hits the line. A dirty mark is set when transactional store data is written back into the line. An invalidation request that names a marked line does not get through at once. The block rejects it in the same cycle, so that the local transaction has a chance to reach its commit. After a programmable number of such rejects, the next conflicting request is accepted and the block raises an abort request. The abort request carries a conflict reason and the line address of the conflict.

Any abort, whether it comes from a conflict or from the core's abort strobe, clears the read marks. It then walks the dirty marks and emits, one line per cycle, the index of each dirty line, because the cache must invalidate those lines. A commit drops all marks in a single cycle and leaves the lines valid. Invalidations to lines without marks are accepted in the cycle they arrive and never stall.

Top module: `txfp_tracker`

## Requirements
- R1: A cycle with `acc_valid` high sets the read mark of line `acc_idx`. From the next cycle, invalidations to that line are treated as conflicts.
- R2: A cycle with `wb_valid` high sets the dirty mark of line `wb_idx`. From the next cycle, invalidations to that line are treated as conflicts.
- R3: A request with `inv_valid` high that names a line holding either mark, while no flush is running and the reject count is below `rej_limit`, gets `inv_reject` in the same cycle, and the reject count increases by one.
- R4: A valid request is answered in its own cycle by exactly one of `inv_reject` or `inv_accept`. A request that names an unmarked line gets `inv_accept`. Neither response is high when `inv_valid` is low.
- R5: A conflicting request that arrives when the reject count equals `rej_limit` is accepted in the same cycle, and `abort_req` is high for exactly the following cycle.
- R6: With `abort_req`, `abort_reason` is 10 (store conflict) if the line held a dirty mark and 9 (fetch conflict) if it held only a read mark. `abort_addr` is the `inv_addr` of that request. Both outputs keep their values until the next conflict abort, and both are 0 after reset.
- R7: In the cycle after any abort, all read marks are clear. From that cycle on, `flush_valid` presents each dirty line once on `flush_idx`, in ascending index order, one line per cycle. While the flush runs, accesses and write-backs are ignored and every invalidation is accepted.
- R8: `tx_commit` outside a flush clears both marks of every line in one cycle. After that, invalidations to those lines are accepted with no abort and no flush.
- R9: The reject count returns to 0 on commit and on any abort, so the next transaction gets its full reject allowance.
- R10: If `tx_abort` and `tx_commit` arrive in the same cycle, the abort wins: the dirty lines are flushed.
- R11: With `rej_limit` at 0, the first conflicting request is accepted at once and starts the abort.
- R12: After reset, no line is marked, and `inv_reject`, `abort_req` and `flush_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Transactional access hit |
| acc_idx | input | IDX_W | Line index of the access |
| wb_valid | input | 1 | Transactional store data written into a line |
| wb_idx | input | IDX_W | Line index of the write-back |
| inv_valid | input | 1 | Incoming invalidation request |
| inv_idx | input | IDX_W | Cache line the invalidation selects |
| inv_addr | input | LINE_ADDR_W | Line address of the invalidation |
| tx_commit | input | 1 | Transaction commit strobe |
| tx_abort | input | 1 | Abort strobe from the core |
| rej_limit | input | CNT_W | Rejects allowed before a conflict aborts |
| inv_reject | output | 1 | Invalidation refused this cycle |
| inv_accept | output | 1 | Invalidation granted this cycle |
| abort_req | output | 1 | One-cycle conflict abort request |
| abort_reason | output | 8 | Conflict reason: 9 fetch, 10 store |
| abort_addr | output | LINE_ADDR_W | Line address of the conflict |
| flush_valid | output | 1 | A dirty line to invalidate is presented |
| flush_idx | output | IDX_W | Index of that dirty line |

## Verification
The assertions check, on every cycle, the rules that need no history beyond one cycle. Each request gets exactly one answer, and an idle cycle gets none. An abort request always follows an accepted request, and a reject is never followed by an abort. The reason code is one of the two legal values, and the conflict information does not change between aborts. No reject is given while a flush is running. Only the bench's scenarios can show that the reject count actually reaches the limit. They also show the ascending order and completeness of the flush list, that commit clears every mark and that commit loses to abort in the same cycle. All of these depend on the footprint that earlier accesses built up.

// File: rtl/txfp_pkg.sv
package txfp_pkg;

    // Width of a line address (byte address without the 256-byte offset)
    localparam int LINE_ADDR_W = 40;

    // Conflict reason codes reported with an abort
    typedef enum logic [7:0] {
        RSN_NONE  = 8'd0,
        RSN_FETCH = 8'd9,
        RSN_STORE = 8'd10
    } reason_e;

    typedef struct packed {
        reason_e                  reason;
        logic [LINE_ADDR_W-1:0]   addr;
    } conflict_t;

    // Reason for a conflict given the dirty mark of the victim line
    function automatic reason_e reason_of(input logic dirty);
        return dirty ? RSN_STORE : RSN_FETCH;
    endfunction

endpackage

// File: rtl/txfp_marks.sv
module txfp_marks #(
    parameter int LINES = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_rd,
    input  logic [IDX_W-1:0] set_rd_idx,
    input  logic             set_dt,
    input  logic [IDX_W-1:0] set_dt_idx,
    input  logic             clr_rd_all,
    input  logic             clr_dt_all,
    input  logic             flush_step,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_rd,
    output logic             look_dt,
    output logic             any_dt,
    output logic [IDX_W-1:0] low_dt_idx
);

    logic [LINES-1:0] rd_q;
    logic [LINES-1:0] dt_q;

    // Read marks
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (clr_rd_all) begin
            rd_q <= '0;
        end else if (set_rd) begin
            rd_q[set_rd_idx] <= 1'b1;
        end
    end

    // Dirty marks: cleared wholesale on commit, one by one while flushing
    always_ff @(posedge clk) begin
        if (rst) begin
            dt_q <= '0;
        end else if (clr_dt_all) begin
            dt_q <= '0;
        end else if (flush_step) begin
            dt_q[low_dt_idx] <= 1'b0;
        end else if (set_dt) begin
            dt_q[set_dt_idx] <= 1'b1;
        end
    end

    // Lowest set dirty mark
    always_comb begin
        low_dt_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (dt_q[i]) begin
                low_dt_idx = IDX_W'(i);
            end
        end
    end

    assign any_dt  = |dt_q;
    assign look_rd = rd_q[look_idx];
    assign look_dt = dt_q[look_idx];

endmodule

// File: rtl/txfp_arbiter.sv
module txfp_arbiter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             hit,
    input  logic             blocked,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr_cnt,
    output logic             reject,
    output logic             accept,
    output logic             conflict
);

    logic [CNT_W-1:0] cnt_q;
    logic             defend;

    // A footprint hit outside a flush is defended while allowance remains
    assign defend   = req && hit && !blocked;
    assign reject   = defend && (cnt_q < limit);
    assign accept   = req && !reject;
    assign conflict = defend && !(cnt_q < limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_cnt || conflict) begin
            cnt_q <= '0;
        end else if (reject) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/txfp_tracker.sv
module txfp_tracker
    import txfp_pkg::*;
#(
    parameter int LINES = 32,
    parameter int CNT_W = 6,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_valid,
    input  logic [IDX_W-1:0]       acc_idx,
    input  logic                   wb_valid,
    input  logic [IDX_W-1:0]       wb_idx,
    input  logic                   inv_valid,
    input  logic [IDX_W-1:0]       inv_idx,
    input  logic [LINE_ADDR_W-1:0] inv_addr,
    input  logic                   tx_commit,
    input  logic                   tx_abort,
    input  logic [CNT_W-1:0]       rej_limit,
    output logic                   inv_reject,
    output logic                   inv_accept,
    output logic                   abort_req,
    output logic [7:0]             abort_reason,
    output logic [LINE_ADDR_W-1:0] abort_addr,
    output logic                   flush_valid,
    output logic [IDX_W-1:0]       flush_idx
);

    logic      flushing_q;
    logic      look_rd, look_dt, any_dt;
    logic      conflict, any_abort, do_commit, live;
    logic      abort_q;
    conflict_t info_q;

    // Abort beats flush beats commit beats marking
    assign any_abort = conflict || tx_abort;
    assign do_commit = tx_commit && !flushing_q && !any_abort;
    assign live      = !flushing_q && !any_abort && !tx_commit;

    txfp_marks #(.LINES(LINES)) u_marks (
        .clk        (clk),
        .rst        (rst),
        .set_rd     (acc_valid && live),
        .set_rd_idx (acc_idx),
        .set_dt     (wb_valid && live),
        .set_dt_idx (wb_idx),
        .clr_rd_all (any_abort || do_commit),
        .clr_dt_all (do_commit),
        .flush_step (flushing_q && !any_abort && any_dt),
        .look_idx   (inv_idx),
        .look_rd    (look_rd),
        .look_dt    (look_dt),
        .any_dt     (any_dt),
        .low_dt_idx (flush_idx)
    );

    txfp_arbiter #(.CNT_W(CNT_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (inv_valid),
        .hit      (look_rd || look_dt),
        .blocked  (flushing_q),
        .limit    (rej_limit),
        .clr_cnt  (tx_abort || tx_commit),
        .reject   (inv_reject),
        .accept   (inv_accept),
        .conflict (conflict)
    );

    // Flush sequencing: enter on abort, leave once no dirty line remains
    always_ff @(posedge clk) begin
        if (rst) begin
            flushing_q <= 1'b0;
        end else if (any_abort) begin
            flushing_q <= 1'b1;
        end else if (flushing_q && !any_dt) begin
            flushing_q <= 1'b0;
        end
    end

    // Conflict capture
    always_ff @(posedge clk) begin
        if (rst) begin
            abort_q     <= 1'b0;
            info_q      <= '{reason: RSN_NONE, addr: '0};
        end else begin
            abort_q <= conflict;
            if (conflict) begin
                info_q.reason <= reason_of(look_dt);
                info_q.addr   <= inv_addr;
            end
        end
    end

    assign abort_req    = abort_q;
    assign abort_reason = info_q.reason;
    assign abort_addr   = info_q.addr;
    assign flush_valid  = flushing_q && any_dt;

endmodule

// File: rtl/txfp_chk.sv
module txfp_chk
    import txfp_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   inv_valid,
    input logic                   inv_reject,
    input logic                   inv_accept,
    input logic                   abort_req,
    input logic [7:0]             abort_reason,
    input logic [LINE_ADDR_W-1:0] abort_addr,
    input logic                   flush_valid
);

    // R4
    resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> $countones({inv_reject, inv_accept}) == 1);

    // R4
    no_resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !inv_valid |-> !inv_reject && !inv_accept);

    // R5
    abort_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> $past(inv_valid && inv_accept));

    // R3
    reject_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        inv_reject |=> !abort_req);

    // R6
    reason_legal_chk: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> (abort_reason == 8'd9 || abort_reason == 8'd10));

    // R6
    info_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !abort_req |-> $stable(abort_addr) && $stable(abort_reason));

    // R7
    no_reject_in_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> !inv_reject);

endmodule

bind txfp_tracker txfp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .inv_valid    (inv_valid),
    .inv_reject   (inv_reject),
    .inv_accept   (inv_accept),
    .abort_req    (abort_req),
    .abort_reason (abort_reason),
    .abort_addr   (abort_addr),
    .flush_valid  (flush_valid)
);

// File: tb/txfp_tracker_test.sv
`timescale 1ns/1ps
module txfp_tracker_test;

    localparam int LINES = 32;
    localparam int CNT_W = 6;
    localparam int IDX_W = $clog2(LINES);
    localparam int AW    = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_valid = 0, wb_valid = 0, inv_valid = 0;
    logic [IDX_W-1:0] acc_idx = '0, wb_idx = '0, inv_idx = '0;
    logic [AW-1:0]    inv_addr = '0;
    logic             tx_commit = 0, tx_abort = 0;
    logic [CNT_W-1:0] rej_limit = '0;
    logic             inv_reject, inv_accept, abort_req, flush_valid;
    logic [7:0]       abort_reason;
    logic [AW-1:0]    abort_addr;
    logic [IDX_W-1:0] flush_idx;

    always #2.5 clk = ~clk;

    txfp_tracker #(.LINES(LINES), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_idx(acc_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .inv_valid(inv_valid), .inv_idx(inv_idx), .inv_addr(inv_addr),
        .tx_commit(tx_commit), .tx_abort(tx_abort), .rej_limit(rej_limit),
        .inv_reject(inv_reject), .inv_accept(inv_accept),
        .abort_req(abort_req), .abort_reason(abort_reason), .abort_addr(abort_addr),
        .flush_valid(flush_valid), .flush_idx(flush_idx)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string scen = "reset";

    // Bench reference state
    logic [LINES-1:0] m_rd = '0, m_dt = '0;
    int               m_cnt = 0;
    logic             m_fl = 0, m_ab = 0;
    logic [7:0]       m_rsn = 8'd0;
    logic [AW-1:0]    m_addr = '0;

    function automatic int lowest(input logic [LINES-1:0] v);
        for (int i = 0; i < LINES; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic e_hit();
        return m_rd[inv_idx] || m_dt[inv_idx];
    endfunction

    function automatic logic e_rej();
        return inv_valid && !m_fl && e_hit() && (m_cnt < int'(rej_limit));
    endfunction

    function automatic logic e_conf();
        return inv_valid && !m_fl && e_hit() && !(m_cnt < int'(rej_limit));
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
        end
    endtask

    task automatic compare();
        chk("R3 reject", 64'(inv_reject), 64'(e_rej()));
        chk("R4 accept", 64'(inv_accept), 64'(inv_valid && !e_rej()));
        chk("R5 abort_req", 64'(abort_req), 64'(m_ab));
        chk("R6 reason", 64'(abort_reason), 64'(m_rsn));
        chk("R6 addr", 64'(abort_addr), 64'(m_addr));
        chk("R7 flush_valid", 64'(flush_valid), 64'(m_fl && (|m_dt)));
        if (m_fl && (|m_dt)) chk("R7 flush_idx", 64'(flush_idx), 64'(lowest(m_dt)));
    endtask

    task automatic update();
        logic conf, rej, ab;
        conf = e_conf();
        rej  = e_rej();
        ab   = conf || tx_abort;
        m_ab = conf;
        if (conf) begin
            m_rsn  = m_dt[inv_idx] ? 8'd10 : 8'd9;
            m_addr = inv_addr;
        end
        if (ab) begin
            m_rd = '0; m_fl = 1'b1; m_cnt = 0;
        end else if (m_fl) begin
            if (m_dt == '0) m_fl = 1'b0;
            else m_dt[lowest(m_dt)] = 1'b0;
        end else if (tx_commit) begin
            m_rd = '0; m_dt = '0; m_cnt = 0;
        end else begin
            if (acc_valid) m_rd[acc_idx] = 1'b1;
            if (wb_valid)  m_dt[wb_idx]  = 1'b1;
            if (rej) m_cnt++;
        end
    endtask

    // Inputs are set after a falling edge; compare, take the rising edge, update.
    task automatic cyc();
        #1;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
        acc_valid = 0; wb_valid = 0; inv_valid = 0; tx_commit = 0; tx_abort = 0;
    endtask

    task automatic inv(input int idx, input logic [AW-1:0] a);
        inv_valid = 1; inv_idx = IDX_W'(idx); inv_addr = a; cyc();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 0;
        // R12: reset state
        scen = "R12 reset state";
        chk("R12 reject low", 64'(inv_reject), 64'd0);
        chk("R12 abort low", 64'(abort_req), 64'd0);
        chk("R12 flush low", 64'(flush_valid), 64'd0);
        inv(5, 40'h5);               // no marks: accepted (R12, R4)

        // R1, R3, R5, R6: read mark, two rejects, then fetch conflict abort
        scen = "R1 R3 R5 fetch conflict";
        rej_limit = 2;
        acc_valid = 1; acc_idx = 5; cyc();
        inv(9, 40'h9);               // R4 miss accepted
        inv(5, 40'hAB_CD05);         // reject
        inv(5, 40'hAB_CD05);         // reject
        inv(5, 40'hAB_CD05);         // accepted, abort next
        idle(3);

        // R2, R6, R7: dirty lines flushed ascending, store conflict reported
        scen = "R2 R7 store conflict flush";
        rej_limit = 1;
        wb_valid = 1; wb_idx = 7; cyc();
        wb_valid = 1; wb_idx = 3; acc_valid = 1; acc_idx = 12; cyc();
        wb_valid = 1; wb_idx = 1; cyc();
        inv(3, 40'h77_0003);         // reject
        inv(3, 40'h77_0003);         // abort with reason 10
        inv(12, 40'h12);             // R7: accepted during flush
        wb_valid = 1; wb_idx = 20; cyc();  // R7: ignored during flush
        idle(5);
        inv(20, 40'h20);             // R7 ignored write-back left no mark

        // R8, R9: commit clears marks and counter
        scen = "R8 R9 commit clears";
        rej_limit = 1;
        acc_valid = 1; acc_idx = 4; wb_valid = 1; wb_idx = 6; cyc();
        inv(4, 40'h4);               // reject, count 1
        tx_commit = 1; cyc();
        inv(4, 40'h4);               // R8 accepted, no abort
        inv(6, 40'h6);               // R8 accepted, no flush
        acc_valid = 1; acc_idx = 4; cyc();
        inv(4, 40'h4);               // R9 reject again after commit
        tx_abort = 1; cyc();         // core abort clears counter
        idle(2);

        // R10: commit and abort together, abort wins
        scen = "R10 commit with abort";
        wb_valid = 1; wb_idx = 9; cyc();
        wb_valid = 1; wb_idx = 2; cyc();
        tx_commit = 1; tx_abort = 1; cyc();
        idle(4);

        // R11: limit 0 aborts on first conflict
        scen = "R11 zero limit";
        rej_limit = 0;
        acc_valid = 1; acc_idx = 30; cyc();
        inv(30, 40'hFF_FF1E);
        idle(3);

        // Random mix
        scen = "random R1-mix";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 99) < 3) rej_limit = CNT_W'($urandom_range(0, 4));
            acc_valid = ($urandom_range(0, 99) < 30);
            acc_idx   = IDX_W'($urandom_range(0, 7));
            wb_valid  = ($urandom_range(0, 99) < 20);
            wb_idx    = IDX_W'($urandom_range(0, 7));
            inv_valid = ($urandom_range(0, 99) < 40);
            inv_idx   = IDX_W'($urandom_range(0, 9));
            inv_addr  = {$urandom(), 8'(n)};
            tx_commit = ($urandom_range(0, 99) < 3);
            tx_abort  = ($urandom_range(0, 99) < 2);
            cyc();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule